// File: doc/BRIEF.md
# Paper Tape Image Loader

This block turns a stream of 8-bit paper-tape characters into writes of 12-bit words into a memory with 15-bit addresses. Characters arrive on a valid/ready handshake, one per clock at most. A single write port drives the memory, which sits outside the block. A start pulse arms the loader. The `mode` input, captured at that pulse, picks one of two tape framings:

- **Plain framing.** Address and data words alternate, there is no checksum, and every store goes to the lowest 4096-word bank.
- **Checked framing.** This framing adds three features. A rubout character discards the character after it. Characters with the high bit set select a memory bank. The last word on the tape is a checksum.

Each load ends in exactly one sticky outcome: done, checksum error, format error (the stream ran dry) or out-of-memory. The outcome stays until the next start pulse.

The controller is one state machine with five states:

- `ST_IDLE` is the state after reset.
- `ST_LEADER` skips leader characters.
- `ST_LOW` waits for the low half of a word.
- `ST_HIGH` waits for the next high half, or for the end mark.
- `ST_FINISH` holds the outcome.

Its transitions are:

- start: any state goes to `ST_LEADER`.
- first data character: `ST_LEADER` goes to `ST_LOW`.
- low half: `ST_LOW` goes to `ST_HIGH`.
- next word: `ST_HIGH` goes to `ST_LOW`.
- end or abort: `ST_HIGH` goes to `ST_FINISH`.
- starved: any busy state goes to `ST_FINISH` on `tape_end`.

Three helpers sit under the controller:

- a character filter, which handles the rubout toggle and the pending bank;
- a checksum accumulator;
- an origin/bank register pair.

Top module: `tape_loader`

## Requirements
- R1: After reset the block is in `ST_IDLE` with all four flags low, `in_ready` low and no write. A `start` pulse clears the flags and enters `ST_LEADER`. It sets the origin to octal 0200 in plain framing and to 0 in checked framing, and it sets the bank to 0. `in_ready` is high exactly in `ST_LEADER`, `ST_LOW` and `ST_HIGH`, and is low during a cycle with `start` high.
- R2: In `ST_LEADER`, a character is skipped when it is 0 or when bit 7 is set. The first other character becomes the high half of the first word. In checked framing the filter of R5 and R6 acts first, and a bank pending when the leader ends is dropped.
- R3: A word is (high<<6)|low, 13 bits wide. When bit 12 of the word is set, bits 11:0 become the new origin and no write happens.
- R4: Plain framing stores each data word at address {3'b000, origin}. `mem_we` is high in the cycle after the low character is accepted, and the origin then steps by one, wrapping from 07777 to 0. A high character with bit 7 set ends the load with `done`.
- R5: Checked framing, rubout: character 0377 sets a toggle, and the next character is discarded whatever its value, including another 0377.
- R6: Checked framing, bank select: a character from 0201 to 0376 is not data. It sets the pending bank to bits 5:3 of the character. The word being assembled is still stored in the old bank, and the bank takes the pending value once that word has been handled.
- R7: Checked framing stores a word at {bank, origin} when the next high character is accepted, with `mem_we` in the following cycle. The origin steps by one, modulo 4096.
- R8: Checked framing, checksum: when character 0200 follows a word, that word is compared with the 12-bit sum of the raw high and low characters of all earlier words. If they are equal, `done` rises; if not, `csum_err` rises.
- R9: Checked framing, memory bound: a store whose {bank, origin} address is at or above `MEM_WORDS` is not written. It raises `nxm_err` and ends the load.
- R10: `tape_end` high while `in_valid` is low in a busy state raises `fmt_err` and ends the load.
- R11: The four flags are mutually exclusive and stay set until `start`. In `ST_FINISH`, `in_ready` is low, and further characters cause no write and no change of flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that arms a new load |
| mode | input | 1 | Framing, sampled at start: 0 plain, 1 checked |
| in_valid | input | 1 | Character valid |
| in_data | input | 8 | Tape character |
| tape_end | input | 1 | No more characters will come |
| in_ready | output | 1 | Loader accepts a character this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 15 | Write address |
| mem_wdata | output | 12 | Write data |
| done | output | 1 | Load completed |
| csum_err | output | 1 | Checksum mismatch |
| fmt_err | output | 1 | Stream ended before the end mark |
| nxm_err | output | 1 | Store beyond configured memory |

## Verification
The bench targets four corner cases, listed here with the failure each one exposes:

- **Rubout followed by a second 0377.** A design that lets the second 0377 set the toggle again would throw away the next data character and shift every later word.
- **Bank character between two words.** This catches a design that applies the bank at once instead of after the current word. Such a design would store the first data word in the new bank.
- **Bank characters seen in the leader.** These must not survive the leader; a design that keeps them would store the first data word in a stray bank.
- **Origin wrap at 07777 in plain framing.** A design without the wrap would write outside bank 0.

The bench also covers mid-load restart, a wrong checksum and a store past the memory bound. In each of these cases the flag must appear once, and nothing may be written after it.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    localparam int CHAR_W  = 8;
    localparam int HALF_W  = 6;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int FIELD_W = 3;
    localparam int ADDR_W  = WORD_W + FIELD_W;

    localparam logic [CHAR_W-1:0] CH_END_MARK = 8'o200;
    localparam logic [CHAR_W-1:0] CH_ESCAPE   = 8'o377;
    localparam logic [WORD_W-1:0] PLAIN_BASE  = 12'o200;

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEADER,
        ST_LOW,
        ST_HIGH,
        ST_FINISH
    } ldr_state_e;

    // Joins a 7-bit high half and an 8-bit low character into a 13-bit word.
    function automatic logic [WORD_W:0] join_halves(input logic [HALF_W:0] hi, input char_t lo);
        return {hi, {HALF_W{1'b0}}} | {{(WORD_W + 1 - CHAR_W){1'b0}}, lo};
    endfunction
endpackage

// File: rtl/ldr_char_filter.sv
module ldr_char_filter
    import ldr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               enable,
    input  logic               take,
    input  char_t              ch,
    input  logic               clr_pend,
    output logic               pass,
    output logic [FIELD_W-1:0] pend_field
);
    logic skip_q;
    logic is_escape;
    logic is_bank;

    assign is_escape = (ch == CH_ESCAPE);
    assign is_bank   = (ch > CH_END_MARK) && !is_escape;
    assign pass      = take && (!enable || (!skip_q && !is_escape && !is_bank));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            skip_q     <= 1'b0;
            pend_field <= '0;
        end else begin
            if (take && enable) begin
                if (skip_q)
                    skip_q <= 1'b0;
                else if (is_escape)
                    skip_q <= 1'b1;
                else if (is_bank)
                    pend_field <= ch[HALF_W-1 -: FIELD_W];
            end
            if (clr_pend)
                pend_field <= '0;
        end
    end
endmodule

// File: rtl/ldr_csum.sv
module ldr_csum
    import ldr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  add,
    input  char_t hi,
    input  char_t lo,
    output word_t sum
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sum <= '0;
        else if (add)
            sum <= sum + WORD_W'(hi) + WORD_W'(lo);
    end
endmodule

// File: rtl/ldr_addr_gen.sv
module ldr_addr_gen
    import ldr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               checked,
    input  logic               load,
    input  word_t              load_val,
    input  logic               inc,
    input  logic               fld_upd,
    input  logic [FIELD_W-1:0] fld_in,
    output word_t              origin,
    output logic [FIELD_W-1:0] field
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            origin <= '0;
            field  <= '0;
        end else if (clr) begin
            origin <= checked ? '0 : PLAIN_BASE;
            field  <= '0;
        end else begin
            if (load)
                origin <= load_val;
            else if (inc)
                origin <= origin + 1'b1;
            if (fld_upd)
                field <= fld_in;
        end
    end
endmodule

// File: rtl/tape_loader.sv
module tape_loader
    import ldr_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              tape_end,
    output logic              in_ready,
    output logic              mem_we,
    output logic [14:0]       mem_addr,
    output logic [11:0]       mem_wdata,
    output logic              done,
    output logic              csum_err,
    output logic              fmt_err,
    output logic              nxm_err
);
    ldr_state_e state, nxt;

    logic               mode_q;
    logic [HALF_W:0]    hi_q;
    char_t              lo_q;
    logic               busy, take, pass;
    logic [FIELD_W-1:0] pend_field, field;
    word_t              origin, csum;
    logic [WORD_W:0]    word_plain, word_chk;
    logic [ADDR_W-1:0]  chk_target;
    logic               chk_beyond;

    logic               do_write, org_load, org_inc, fld_upd, cs_add;
    logic               hi_load, lo_load, clr_pend;
    logic               set_done, set_cs, set_fmt, set_nxm;
    logic [ADDR_W-1:0]  wr_addr_c;
    word_t              wr_data_c, org_val;

    assign busy       = (state == ST_LEADER) || (state == ST_LOW) || (state == ST_HIGH);
    assign in_ready   = busy && !start;
    assign take       = in_valid && in_ready;
    assign word_plain = join_halves(hi_q, in_data);
    assign word_chk   = join_halves(hi_q, lo_q);
    assign chk_target = {field, origin};
    assign chk_beyond = (32'(chk_target) >= MEM_WORDS);

    ldr_char_filter u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start),
        .enable     (mode_q),
        .take       (take),
        .ch         (in_data),
        .clr_pend   (clr_pend),
        .pass       (pass),
        .pend_field (pend_field)
    );

    ldr_csum u_csum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .add   (cs_add),
        .hi    ({1'b0, hi_q}),
        .lo    (lo_q),
        .sum   (csum)
    );

    ldr_addr_gen u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .checked  (mode),
        .load     (org_load),
        .load_val (org_val),
        .inc      (org_inc),
        .fld_upd  (fld_upd),
        .fld_in   (pend_field),
        .origin   (origin),
        .field    (field)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Captured framing and word halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            if (start)
                mode_q <= mode;
            if (hi_load)
                hi_q <= in_data[HALF_W:0];
            if (lo_load)
                lo_q <= in_data;
        end
    end

    // Next state and datapath controls
    always_comb begin
        nxt       = state;
        do_write  = 1'b0;
        wr_addr_c = '0;
        wr_data_c = '0;
        org_load  = 1'b0;
        org_val   = '0;
        org_inc   = 1'b0;
        fld_upd   = 1'b0;
        cs_add    = 1'b0;
        hi_load   = 1'b0;
        lo_load   = 1'b0;
        clr_pend  = 1'b0;
        set_done  = 1'b0;
        set_cs    = 1'b0;
        set_fmt   = 1'b0;
        set_nxm   = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_LEADER: begin
                if (pass && (in_data != '0) && !in_data[CHAR_W-1]) begin
                    hi_load  = 1'b1;
                    clr_pend = 1'b1;
                    nxt      = ST_LOW;
                end
            end
            ST_LOW: begin
                if (pass) begin
                    if (mode_q) begin
                        lo_load = 1'b1;
                    end else if (word_plain[WORD_W]) begin
                        org_load = 1'b1;
                        org_val  = word_plain[WORD_W-1:0];
                    end else begin
                        do_write  = 1'b1;
                        wr_addr_c = {{FIELD_W{1'b0}}, origin};
                        wr_data_c = word_plain[WORD_W-1:0];
                        org_inc   = 1'b1;
                    end
                    nxt = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (pass) begin
                    if (!mode_q) begin
                        if (in_data[CHAR_W-1]) begin
                            set_done = 1'b1;
                            nxt      = ST_FINISH;
                        end else begin
                            hi_load = 1'b1;
                            nxt     = ST_LOW;
                        end
                    end else if (in_data == CH_END_MARK) begin
                        if (csum == word_chk[WORD_W-1:0])
                            set_done = 1'b1;
                        else
                            set_cs = 1'b1;
                        nxt = ST_FINISH;
                    end else if (word_chk[WORD_W]) begin
                        org_load = 1'b1;
                        org_val  = word_chk[WORD_W-1:0];
                        cs_add   = 1'b1;
                        fld_upd  = 1'b1;
                        hi_load  = 1'b1;
                        nxt      = ST_LOW;
                    end else if (chk_beyond) begin
                        set_nxm = 1'b1;
                        nxt     = ST_FINISH;
                    end else begin
                        do_write  = 1'b1;
                        wr_addr_c = chk_target;
                        wr_data_c = word_chk[WORD_W-1:0];
                        org_inc   = 1'b1;
                        cs_add    = 1'b1;
                        fld_upd   = 1'b1;
                        hi_load   = 1'b1;
                        nxt       = ST_LOW;
                    end
                end
            end
            ST_FINISH: begin
            end
            default: nxt = ST_IDLE;
        endcase
        if (busy && tape_end && !in_valid && !start) begin
            set_fmt = 1'b1;
            nxt     = ST_FINISH;
        end
        if (start)
            nxt = ST_LEADER;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            csum_err  <= 1'b0;
            fmt_err   <= 1'b0;
            nxm_err   <= 1'b0;
        end else begin
            mem_we <= do_write;
            if (do_write) begin
                mem_addr  <= wr_addr_c;
                mem_wdata <= wr_data_c;
            end
            if (start) begin
                done     <= 1'b0;
                csum_err <= 1'b0;
                fmt_err  <= 1'b0;
                nxm_err  <= 1'b0;
            end else begin
                done     <= done     | set_done;
                csum_err <= csum_err | set_cs;
                fmt_err  <= fmt_err  | set_fmt;
                nxm_err  <= nxm_err  | set_nxm;
            end
        end
    end
endmodule

// File: rtl/tape_loader_checker.sv
module tape_loader_checker #(
    parameter int unsigned MEM_WORDS = 32768
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        in_valid,
    input logic        in_ready,
    input logic        mem_we,
    input logic [14:0] mem_addr,
    input logic        mode_q,
    input logic        done,
    input logic        csum_err,
    input logic        fmt_err,
    input logic        nxm_err
);
    logic any_flag;
    assign any_flag = done | csum_err | fmt_err | nxm_err;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, csum_err, fmt_err, nxm_err})); // R11
    AST_NO_WRITE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) (any_flag && !start) |=> !mem_we); // R11
    AST_NOT_READY_WHEN_ENDED: assert property (@(posedge clk) disable iff (!rst_n) any_flag |-> !in_ready); // R11
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done); // R11
    AST_WRITE_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (32'(mem_addr) < MEM_WORDS)); // R9
    AST_PLAIN_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && !mode_q) |-> (mem_addr[14:12] == 3'b000)); // R4
    AST_WRITE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> $past(in_valid && in_ready)); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start |=> !any_flag); // R1
endmodule

bind tape_loader tape_loader_checker #(.MEM_WORDS(MEM_WORDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mode_q   (mode_q),
    .done     (done),
    .csum_err (csum_err),
    .fmt_err  (fmt_err),
    .nxm_err  (nxm_err)
);

// File: tb/tape_loader_tb.sv
`timescale 1ns/1ps
module tape_loader_tb;
    localparam int unsigned MEM_W = 20480;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        tape_end = 1'b0;
    logic        in_ready, mem_we, done, csum_err, fmt_err, nxm_err;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;

    always #4 clk = ~clk;

    tape_loader #(.MEM_WORDS(MEM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .in_valid(in_valid), .in_data(in_data), .tape_end(tape_end),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .csum_err(csum_err),
        .fmt_err(fmt_err), .nxm_err(nxm_err)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    int    mem [int];

    // Behavioural reference model: 0 idle, 1 leader, 2 low, 3 high, 4 finished
    int m_st = 0, m_mode = 0, m_skip = 0, m_pend = 0, m_field = 0, m_org = 0, m_sum = 0;
    int m_hi = 0, m_lo = 0, m_wd = 0;
    int m_done = 0, m_cs = 0, m_fmt = 0, m_nxm = 0;
    int m_we = 0, m_addr = 0, m_data = 0;

    task automatic m_write(input int a, input int d);
        m_we = 1; m_addr = a; m_data = d;
    endtask

    task automatic m_char(input int c);
        if (m_mode == 1) begin
            if (m_skip == 1) begin m_skip = 0; return; end
            if (c == 'o377) begin m_skip = 1; return; end
            if (c > 'o200) begin m_pend = (c & 'o70) << 9; return; end
        end
        case (m_st)
            1: if (c != 0 && c < 'o200) begin m_hi = c; m_pend = 0; m_st = 2; end
            2: begin
                if (m_mode == 1) begin
                    m_lo = c; m_st = 3;
                end else begin
                    m_wd = (m_hi << 6) | c;
                    if (m_wd > 'o7777) m_org = m_wd & 'o7777;
                    else begin m_write(m_org, m_wd & 'o7777); m_org = (m_org + 1) & 'o7777; end
                    m_st = 3;
                end
            end
            3: begin
                if (m_mode == 0) begin
                    if (c >= 'o200) begin m_done = 1; m_st = 4; end
                    else begin m_hi = c; m_st = 2; end
                end else begin
                    m_wd = (m_hi << 6) | m_lo;
                    if (c == 'o200) begin
                        if (((m_sum - m_wd) & 'o7777) == 0) m_done = 1; else m_cs = 1;
                        m_st = 4;
                    end else begin
                        if (m_wd > 'o7777) m_org = m_wd & 'o7777;
                        else if ((m_field | m_org) >= int'(MEM_W)) begin m_nxm = 1; m_st = 4; return; end
                        else begin m_write(m_field | m_org, m_wd & 'o7777); m_org = (m_org + 1) & 'o7777; end
                        m_sum = (m_sum + m_hi + m_lo) & 'o7777;
                        m_field = m_pend;
                        m_hi = c; m_st = 2;
                    end
                end
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        m_we = 0;
        if (!rst_n) begin
            m_st = 0; m_done = 0; m_cs = 0; m_fmt = 0; m_nxm = 0;
        end else if (start) begin
            m_st = 1; m_mode = mode ? 1 : 0; m_skip = 0; m_pend = 0; m_field = 0;
            m_org = mode ? 0 : 'o200; m_sum = 0;
            m_done = 0; m_cs = 0; m_fmt = 0; m_nxm = 0;
        end else if (m_st >= 1 && m_st <= 3 && in_valid) begin
            m_char(int'(in_data));
        end else if (m_st >= 1 && m_st <= 3 && tape_end) begin
            m_fmt = 1; m_st = 4;
        end
    end

    // Cycle comparison and memory capture at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_rdy;
            exp_rdy = (m_st >= 1 && m_st <= 3 && !start) ? 1 : 0;
            n_chk++;
            if (int'(in_ready) != exp_rdy || int'(mem_we) != m_we ||
                (m_we == 1 && (int'(mem_addr) != m_addr || int'(mem_wdata) != m_data)) ||
                int'(done) != m_done || int'(csum_err) != m_cs ||
                int'(fmt_err) != m_fmt || int'(nxm_err) != m_nxm) begin
                n_bad++;
                $display("FAIL [%s] t=%0t act rdy=%0d we=%0d a=%o d=%o flags=%0d%0d%0d%0d exp rdy=%0d we=%0d a=%o d=%o flags=%0d%0d%0d%0d",
                    cur_req, $time, in_ready, mem_we, mem_addr, mem_wdata, done, csum_err, fmt_err, nxm_err,
                    exp_rdy, m_we, m_addr, m_data, m_done, m_cs, m_fmt, m_nxm);
            end
            if (mem_we) mem[int'(mem_addr)] = int'(mem_wdata);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] act=%o exp=%o", req, act, exp);
        end
    endtask

    function automatic int rd(input int a);
        return mem.exists(a) ? mem[a] : -1;
    endfunction

    task automatic do_start(input logic m);
        @(negedge clk); #1; in_valid = 1'b0; start = 1'b1; mode = m;
        @(negedge clk); #1; start = 1'b0;
    endtask

    task automatic send(input int c);
        @(negedge clk); #1; in_valid = 1'b1; in_data = 8'(c);
    endtask

    task automatic pause(input int n);
        @(negedge clk); #1; in_valid = 1'b0;
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL [watchdog] act=hung exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(in_ready), 0);
        chk("R1", int'(done | csum_err | fmt_err | nxm_err), 0);

        // T1 plain framing with leader and origin word: R2 R3 R4
        cur_req = "R4"; mem.delete();
        do_start(1'b0);
        send(0); send(0); send('o200); send('o210);
        send('o110); send(0);
        send('o12); send('o34);
        pause(1);
        send('o70); send('o70);
        send('o200);
        pause(3);
        chk("R3", rd('o1000), 'o1234);
        chk("R4", rd('o1001), 'o7070);
        chk("R4", int'(done), 1);
        chk("R2", mem.num(), 2);
        // R11 characters after the end are ignored
        cur_req = "R11";
        send(1); send(2); send(3);
        pause(3);
        chk("R11", mem.num(), 2);
        chk("R11", int'(done), 1);
        chk("R11", int'(in_ready), 0);

        // T2 plain default origin and wrap: R4
        cur_req = "R4"; mem.delete();
        do_start(1'b0);
        send(1); send('o5);
        send('o177); send('o77);
        send(0); send(2);
        send(0); send(3);
        send('o377);
        pause(3);
        chk("R4", rd('o200), 'o105);
        chk("R4", rd('o7777), 2);
        chk("R4", rd(0), 3);
        chk("R4", int'(done), 1);

        // T3 checked framing: rubout, bank change, checksum: R5 R6 R7 R8
        cur_req = "R7"; mem.delete();
        do_start(1'b1);
        send('o377); send('o45);
        send('o200); send('o230);
        send('o105); send(0);
        send(1); send('o11);
        send('o220);
        send(2); send('o22);
        send('o377); send('o377);
        send(3); send('o33);
        send(2); send(1);
        send('o200);
        pause(3);
        chk("R6", rd('o500), 'o111);
        chk("R6", rd('o20501), 'o222);
        chk("R5", rd('o20502), 'o333);
        chk("R7", mem.num(), 3);
        chk("R8", int'(done), 1);
        chk("R8", int'(csum_err), 0);

        // T4 wrong checksum: R8
        cur_req = "R8"; mem.delete();
        do_start(1'b1);
        send('o101); send(0);
        send(7); send(7);
        send(1); send('o20);
        send('o200);
        pause(3);
        chk("R8", rd('o100), 'o707);
        chk("R8", int'(csum_err), 1);
        chk("R8", int'(done), 0);

        // T5 store beyond memory: R9
        cur_req = "R9"; mem.delete();
        do_start(1'b1);
        send('o100); send(0);
        send('o250);
        send(1); send(1);
        send(2); send(2);
        send(3); send(3);
        pause(3);
        chk("R9", int'(nxm_err), 1);
        chk("R9", mem.num(), 0);
        chk("R11", int'(in_ready), 0);

        // T6 stream runs dry: R10
        cur_req = "R10"; mem.delete();
        do_start(1'b1);
        send('o101); send(0);
        pause(2);
        @(negedge clk); #1; tape_end = 1'b1;
        @(negedge clk); #1; tape_end = 1'b0;
        pause(2);
        chk("R10", int'(fmt_err), 1);
        chk("R10", int'(done), 0);

        // T7 restart in mid-load: R1
        cur_req = "R1"; mem.delete();
        do_start(1'b0);
        send('o101); send(0);
        send(1);
        do_start(1'b0);
        chk("R1", int'(fmt_err), 0);
        send(1); send(2);
        send('o200);
        pause(3);
        chk("R1", rd('o200), 'o102);
        chk("R1", int'(done), 1);

        finish_run();
    end
endmodule